// File: doc/BRIEF.md
# Address-Range Trace Enable Filter

This block decides, one access at a time, whether the access should be traced. It holds a configurable number of comparator pairs. Each pair bounds an inclusive address range, and each comparator carries its own access-kind qualifier. Every access presented with its valid strobe is tested against all ranges. The ranges chosen by a select mask are combined into one hit, and a global flag turns that hit into an exclude region instead of an include region. The decision appears on `trace_en` one cycle after the access.

Software configures the block through a small word-addressed register port. Reads are combinational and writes take effect at the clock edge. Before it changes the comparators or the enable control, software raises a programming-mode request. It then polls the same bit until the acknowledge reads back as 1, which happens two cycles after the request. To resume filtering, it clears the request and waits for the bit to read back as 0. Trace output is held low for as long as a request or its acknowledge is pending.

Top module: `addr_range_trace_filter`

## Requirements
- R1: The word at offset 0x004 is read-only and returns the number of comparator pairs (parameter NPAIRS) in bits 3:0, with all other bits zero.
- R2: Writing bit 10 of the word at offset 0x000 sets or clears the programming-mode request. Bit 10 of that word reads back the acknowledge, which equals the request as it stood exactly two clock edges earlier.
- R3: A 4-bit port-size value written to offset 0x000 is held with its low 3 bits in bits 6:4 and its top bit in bit 21, reads back in those positions, and can be written at any time.
- R4: Comparator i holds its address at offset 0x040 + 4*i and its access-type code in bits 2:0 at offset 0x080 + 4*i. Range n, counted from 1, has comparator 2(n-1) as its start and comparator 2(n-1)+1 as its end.
- R5: In the enable word at offset 0x024, bit n-1 selects range n and bit 24 makes the selected ranges exclude regions. Ranges whose bit is clear have no effect on the output.
- R6: Writes to the comparator, access-type and enable words are ignored while the acknowledge is 0.
- R7: An address is inside a range when it is greater than or equal to the start and less than or equal to the end. Both bounds are included.
- R8: Access kinds are coded 0 fetch, 1 execute, 2 execute with condition passed, 3 execute with condition failed, 4 load or store, 5 load, 6 store. A comparator accepts a kind equal to its type code. Type 1 also accepts kinds 2 and 3, and type 4 also accepts kinds 5 and 6. A range hits only when both of its comparators accept the kind.
- R9: `trace_en` is registered. One cycle after an access with `acc_valid` high, it equals (any selected range hits) XOR exclude. After a cycle without a valid access it is 0.
- R10: `trace_en` is 0 in the cycle after any cycle in which the programming-mode request or its acknowledge is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | RAW | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational on reg_addr) |
| acc_valid | input | 1 | Access valid strobe |
| acc_addr | input | AW | Access address |
| acc_kind | input | 3 | Access kind code |
| trace_en | output | 1 | Registered trace-enable decision |

## Verification
Almost any corrupt internal state shows on `trace_en` at the first valid access after it. A bad bound, a wrong type code or a lost select bit flips the decision for addresses at the range edges or for one access kind, so the bench tests exactly those edges and kinds. A handshake pipeline of the wrong length shows within three cycles of a request edge, because bit 10 reads back too early or too late. A write that leaks through while the block is not in programming mode shows immediately on read-back of that register, and it also changes the filter decision at the next access.

// File: rtl/addr_range_trace_filter.sv
module addr_range_trace_filter #(
  parameter int NPAIRS = 4,
  parameter int AW = 32,
  parameter int RAW = 12
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           reg_wr,
  input  logic [RAW-1:0] reg_addr,
  input  logic [31:0]    reg_wdata,
  output logic [31:0]    reg_rdata,
  input  logic           acc_valid,
  input  logic [AW-1:0]  acc_addr,
  input  logic [2:0]     acc_kind,
  output logic           trace_en
);
  localparam int NCMP = 2 * NPAIRS;
  localparam logic [RAW-1:0] CTRL_A = RAW'(12'h000);
  localparam logic [RAW-1:0] CFG_A  = RAW'(12'h004);
  localparam logic [RAW-1:0] TEN_A  = RAW'(12'h024);
  localparam logic [RAW-1:0] VAL_A  = RAW'(12'h040);
  localparam logic [RAW-1:0] TYP_A  = RAW'(12'h080);

  logic              prog_req, ack_d1, prog_ack, excl;
  logic [3:0]        psz;
  logic [NPAIRS-1:0] sel, rhit;
  logic [AW-1:0]     cval [NCMP];
  logic [2:0]        ctyp [NCMP];
  logic [NCMP-1:0]   kok;

  wire busy   = prog_req | prog_ack;
  wire cfg_wr = reg_wr & prog_ack;

  function automatic logic kind_ok(input logic [2:0] t, input logic [2:0] k);
    return (t == k)
        || (t == 3'd1 && (k == 3'd2 || k == 3'd3))
        || (t == 3'd4 && (k == 3'd5 || k == 3'd6));
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prog_req <= 1'b0;
      ack_d1   <= 1'b0;
      prog_ack <= 1'b0;
      psz      <= '0;
      sel      <= '0;
      excl     <= 1'b0;
    end else begin
      ack_d1   <= prog_req;
      prog_ack <= ack_d1;
      if (reg_wr && reg_addr == CTRL_A) begin
        prog_req <= reg_wdata[10];
        psz      <= {reg_wdata[21], reg_wdata[6:4]};
      end
      if (cfg_wr && reg_addr == TEN_A) begin
        sel  <= reg_wdata[NPAIRS-1:0];
        excl <= reg_wdata[24];
      end
    end
  end

  always_ff @(posedge clk) begin
    for (int c = 0; c < NCMP; c++) begin
      if (!rst_n) begin
        cval[c] <= '0;
        ctyp[c] <= '0;
      end else begin
        if (cfg_wr && reg_addr == VAL_A + RAW'(4 * c)) cval[c] <= reg_wdata[AW-1:0];
        if (cfg_wr && reg_addr == TYP_A + RAW'(4 * c)) ctyp[c] <= reg_wdata[2:0];
      end
    end
  end

  for (genvar c = 0; c < NCMP; c++) begin : g_cmp
    assign kok[c] = kind_ok(ctyp[c], acc_kind);
  end

  for (genvar p = 0; p < NPAIRS; p++) begin : g_rng
    assign rhit[p] = (acc_addr >= cval[2*p]) && (acc_addr <= cval[2*p+1])
                  && kok[2*p] && kok[2*p+1];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) trace_en <= 1'b0;
    else        trace_en <= acc_valid && !busy && ((|(rhit & sel)) ^ excl);
  end

  always_comb begin
    reg_rdata = '0;
    if (reg_addr == CTRL_A) begin
      reg_rdata[21]  = psz[3];
      reg_rdata[10]  = prog_ack;
      reg_rdata[6:4] = psz[2:0];
    end
    if (reg_addr == CFG_A) reg_rdata[3:0] = 4'(NPAIRS);
    if (reg_addr == TEN_A) begin
      reg_rdata[NPAIRS-1:0] = sel;
      reg_rdata[24]         = excl;
    end
    for (int c = 0; c < NCMP; c++) begin
      if (reg_addr == VAL_A + RAW'(4 * c)) reg_rdata[AW-1:0] = cval[c];
      if (reg_addr == TYP_A + RAW'(4 * c)) reg_rdata[2:0]    = ctyp[c];
    end
  end
endmodule

module trace_filter_chk #(
  parameter int NPAIRS = 4,
  parameter int RAW = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic [RAW-1:0]    reg_addr,
  input logic [3:0]        rd_nib,
  input logic              acc_valid,
  input logic              trace_en,
  input logic              prog_req,
  input logic              prog_ack,
  input logic [NPAIRS-1:0] sel,
  input logic              excl
);
  // R2
  ack_lag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    prog_ack == $past(prog_req, 2));

  // R10
  busy_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (prog_req || prog_ack) |=> !trace_en);

  // R9
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_valid |=> !trace_en);

  // R6
  locked_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !prog_ack |=> ($stable(sel) && $stable(excl)));

  // R1
  cfg_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == RAW'(12'h004)) |-> (rd_nib == 4'(NPAIRS)));
endmodule

bind addr_range_trace_filter trace_filter_chk #(.NPAIRS(NPAIRS), .RAW(RAW)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .rd_nib(reg_rdata[3:0]),
  .acc_valid(acc_valid), .trace_en(trace_en), .prog_req(prog_req),
  .prog_ack(prog_ack), .sel(sel), .excl(excl)
);

// File: tb/test_addr_range_trace_filter.sv
module test_addr_range_trace_filter;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        reg_wr = 0;
  logic [11:0] reg_addr = 0;
  logic [31:0] reg_wdata = 0;
  logic [31:0] reg_rdata;
  logic        acc_valid = 0;
  logic [31:0] acc_addr = 0;
  logic [2:0]  acc_kind = 0;
  logic        trace_en;
  int total = 0, bad = 0;

  always #5 clk = ~clk;

  addr_range_trace_filter i_addr_range_trace_filter (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .acc_valid(acc_valid),
    .acc_addr(acc_addr), .acc_kind(acc_kind), .trace_en(trace_en));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk); reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] v);
    @(negedge clk); reg_addr = a; #1 v = reg_rdata;
  endtask

  task automatic acc(input logic [31:0] a, input logic [2:0] k, output logic te);
    @(negedge clk); acc_valid = 1; acc_addr = a; acc_kind = k;
    @(negedge clk); acc_valid = 0; #1 te = trace_en;
  endtask

  task automatic enter_prog();
    wr(12'h000, 32'h400);
    repeat (2) @(negedge clk);
  endtask

  task automatic leave_prog();
    wr(12'h000, 32'h0);
    repeat (2) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [31:0] v;
    rd(12'h000, v); chk("R2 reset ctrl", v, 0);
    rd(12'h004, v); chk("R1 pair count", v, 4);
    rd(12'h024, v); chk("R5 reset enable", v, 0);
    chk("R9 reset trace_en", {31'b0, trace_en}, 0);
  endtask

  task automatic t_handshake();
    logic [31:0] v;
    wr(12'h000, 32'h400);
    rd(12'h000, v); chk("R2 ack not yet", v[10], 0);
    rd(12'h000, v); chk("R2 ack after two", v[10], 1);
    wr(12'h000, 32'h0);
    rd(12'h000, v); chk("R2 ack still held", v[10], 1);
    rd(12'h000, v); chk("R2 ack released", v[10], 0);
  endtask

  task automatic t_program();
    logic [31:0] v;
    logic te;
    enter_prog();
    wr(12'h040, 32'h1000); wr(12'h044, 32'h1FFF);
    wr(12'h080, 32'hFFFF_FFF9); wr(12'h084, 32'h1);
    wr(12'h048, 32'h8000); wr(12'h04C, 32'h80FF);
    wr(12'h088, 32'h4); wr(12'h08C, 32'h4);
    wr(12'h024, 32'h1);
    rd(12'h044, v); chk("R4 comparator value", v, 32'h1FFF);
    rd(12'h080, v); chk("R4 type low bits", v, 32'h1);
    rd(12'h024, v); chk("R5 enable readback", v, 32'h1);
    leave_prog();
    acc(32'h1000, 3'd2, te); chk("R7 start bound", te, 1);
    acc(32'h1FFF, 3'd2, te); chk("R7 end bound", te, 1);
    acc(32'h0FFF, 3'd2, te); chk("R7 below start", te, 0);
    acc(32'h2000, 3'd2, te); chk("R7 above end", te, 0);
    acc(32'h1500, 3'd3, te); chk("R8 cond fail kind", te, 1);
    acc(32'h1500, 3'd1, te); chk("R8 exact kind", te, 1);
    acc(32'h1500, 3'd0, te); chk("R8 fetch rejected", te, 0);
    acc(32'h1500, 3'd5, te); chk("R8 load rejected", te, 0);
    acc(32'h8010, 3'd5, te); chk("R5 unselected range", te, 0);
  endtask

  task automatic t_both();
    logic te;
    enter_prog(); wr(12'h024, 32'h3); leave_prog();
    acc(32'h8010, 3'd5, te); chk("R8 load in data range", te, 1);
    acc(32'h8010, 3'd6, te); chk("R8 store in data range", te, 1);
    acc(32'h80FF, 3'd4, te); chk("R8 load-store exact", te, 1);
    acc(32'h8010, 3'd2, te); chk("R8 exec in data range", te, 0);
    acc(32'h1800, 3'd2, te); chk("R9 first range still", te, 1);
  endtask

  task automatic t_exclude();
    logic te;
    enter_prog(); wr(12'h024, 32'h0100_0001); leave_prog();
    acc(32'h1800, 3'd2, te); chk("R5 exclude inside", te, 0);
    acc(32'h3000, 3'd0, te); chk("R5 exclude outside", te, 1);
  endtask

  task automatic t_locked();
    logic [31:0] v;
    logic te;
    wr(12'h024, 32'h0);
    wr(12'h040, 32'h5555);
    rd(12'h040, v); chk("R6 value write ignored", v, 32'h1000);
    rd(12'h024, v); chk("R6 enable write ignored", v, 32'h0100_0001);
    acc(32'h3000, 3'd0, te); chk("R6 filter unchanged", te, 1);
  endtask

  task automatic t_busy();
    logic te;
    wr(12'h000, 32'h400);
    acc(32'h3000, 3'd0, te); chk("R10 low on request", te, 0);
    repeat (2) @(negedge clk);
    acc(32'h3000, 3'd0, te); chk("R10 low on ack", te, 0);
    leave_prog();
    acc(32'h3000, 3'd0, te); chk("R10 resumes", te, 1);
  endtask

  task automatic t_idle();
    @(negedge clk); #1;
    chk("R9 no valid", {31'b0, trace_en}, 0);
  endtask

  task automatic t_portsize();
    logic [31:0] v;
    wr(12'h000, 32'h0020_0020);
    rd(12'h000, v); chk("R3 port size fields", v, 32'h0020_0020);
    wr(12'h000, 32'h0000_0070);
    rd(12'h000, v); chk("R3 low size bits", v, 32'h0000_0070);
  endtask

  initial begin
    #2_000_000;
    bad++; total++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_handshake();
    t_program();
    t_both();
    t_exclude();
    t_locked();
    t_busy();
    t_idle();
    t_portsize();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule